// File: doc/BRIEF.md
# Descriptor Ring Pointer Controller

This block is the control and status register bank for one command/response descriptor ring that host software and a transfer engine share. Software places descriptors in memory and moves an enqueue pointer forward. The engine consumes descriptors and reports each finished one with a completion pulse, which moves a hardware-owned dequeue pointer forward. The block keeps the three software pointers and the hardware pointer, and it tells the engine when work is waiting. It also flags the empty and full ring conditions and gathers ring events into a maskable interrupt.

Software reaches the bank through a simple word register port. Writes take effect at the clock edge. Read data is registered and is valid one cycle after the read strobe. Memory access and descriptor fetch stay outside the block. Events from the engine and the in-band interrupt path come in as single-cycle pulses.

The ring can be enabled or halted. It can also be aborted: an abort locks the ring until the engine reports that nothing is in flight. The ring then enters the aborted state and raises a ring-operation interrupt. Writing the control register again with only the enable bit set starts the ring once more.

Top module: `ring_ptr_ctrl`

Register word offsets (byte address / 4):

| Offset | Register |
|---|---|
| 0 | setup |
| 1 | control |
| 2 | state |
| 3 | pointer word A |
| 4 | pointer word B |
| 5 | interrupt status |
| 6 | interrupt status-enable |
| 7 | interrupt signal-enable |
| 8 | interrupt force |

## Requirements
- R1: After reset, these are all zero: every pointer, the control and state registers, the interrupt registers, `eng_req_o` and `irq_o`. `ring_empty_o` is 1 and `ring_full_o` is 0. The setup register reads back as transfer structure size in bits 31:24, response structure size in bits 23:16, and ring size in bits 8:0. With the default parameters it reads 0x0C040010.
- R2: Pointer word A is readable and writable by software. Bits 23:16 hold the in-band interrupt dequeue pointer, bits 15:8 the software dequeue pointer, and bits 7:0 the enqueue pointer. All other bits read as zero.
- R3: Pointer word B is read-only. Bits 23:16 show `ibi_hw_enq_i` and bits 7:0 show the hardware dequeue pointer. Writes to it have no effect.
- R4: `eng_req_o` is 1 only when all of these hold: enable (control bit 0) is set, halt (control bit 1) is clear, the ring is neither locked nor aborted, and the enqueue pointer differs from the hardware dequeue pointer. The state register shows running in bit 1 and enabled in bit 0.
- R5: A completion pulse on `eng_done_i` while the ring is not empty moves the hardware dequeue pointer forward by one, modulo the ring size. A pulse while the ring is empty changes nothing.
- R6: `ring_empty_o` is 1 when the enqueue pointer equals the hardware dequeue pointer. `ring_full_o` is 1 when the enqueue pointer plus one, modulo the ring size, equals the hardware dequeue pointer.
- R7: An accepted completion sets transfer-complete (bit 11). If `eng_err_i` is set on the same pulse, it sets transfer-error (bit 9) instead.
- R8: An interrupt status bit is recorded only while its status-enable bit is set. Only bits 12, 11, 10, 9, 7, 6 and 5 exist; all other bits read as zero.
- R9: Writing ones to the interrupt status register clears those bits.
- R10: `irq_o` is 1 exactly when some status bit is set and its signal-enable bit is set. It changes at the same edge as the status register.
- R11: Writing the force register sets the matching status bits, subject to status-enable. A source event arriving in the same cycle as a clear of that bit leaves the bit set.
- R12: Writing control bit 2 locks the ring: state bit 3 is set and requests stop. At the first edge where `eng_busy_i` is low, the ring becomes aborted: state bit 2 is set, state bit 3 clears, and ring-op (bit 10) is set. Writing control without bit 2 clears the abort and restarts the ring.
- R13: Each event input sets its own status bit: `evt_ibi_ready_i` sets bit 12, `evt_ins_stop_i` sets bit 7, `evt_ibi_full_i` sets bit 6, and `evt_xfer_abort_i` sets bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | ADDR_W | byte address of register |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, valid one cycle after reg_rd |
| eng_req_o | output | 1 | work available to the engine |
| eng_done_i | input | 1 | one descriptor completed (pulse) |
| eng_err_i | input | 1 | completion ended in error |
| eng_busy_i | input | 1 | engine has a transfer in flight |
| ibi_hw_enq_i | input | PTR_W | hardware in-band interrupt enqueue pointer |
| evt_ibi_ready_i | input | 1 | in-band interrupt ready event |
| evt_ins_stop_i | input | 1 | inserted-stop warning event |
| evt_ibi_full_i | input | 1 | in-band interrupt ring full event |
| evt_xfer_abort_i | input | 1 | transfer aborted event |
| ring_empty_o | output | 1 | ring has no pending descriptor |
| ring_full_o | output | 1 | ring cannot take another descriptor |
| irq_o | output | 1 | interrupt request |

## Verification
A corrupted hardware dequeue pointer becomes visible on `ring_empty_o`, `ring_full_o` and `eng_req_o` in the same cycle. A read of pointer word B shows it one cycle after the read strobe. A lost or wrongly steered completion appears as a missing or misplaced bit 11 or bit 9 on the next status read. If `irq_o` is out of step with status and signal-enable, the error shows at the very edge where either one changes. An abort that never completes stays visible as the locked bit in the state register and as no ring-op status bit after `eng_busy_i` falls.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
  localparam int IRQ_W = 13;

  localparam int IRQ_IBI_RDY   = 12;
  localparam int IRQ_XFER_DONE = 11;
  localparam int IRQ_RING_OP   = 10;
  localparam int IRQ_XFER_ERR  = 9;
  localparam int IRQ_INS_STOP  = 7;
  localparam int IRQ_IBI_FULL  = 6;
  localparam int IRQ_XFER_ABT  = 5;

  localparam logic [IRQ_W-1:0] IRQ_IMPL = 13'h1EE0;

  localparam int REG_SETUP  = 0;
  localparam int REG_CTRL   = 1;
  localparam int REG_STATE  = 2;
  localparam int REG_PTRA   = 3;
  localparam int REG_PTRB   = 4;
  localparam int REG_ISTAT  = 5;
  localparam int REG_IEN    = 6;
  localparam int REG_ISIG   = 7;
  localparam int REG_IFORCE = 8;

  typedef enum logic [1:0] {
    RS_NORMAL  = 2'd0,
    RS_LOCKED  = 2'd1,
    RS_ABORTED = 2'd2
  } ring_state_e;
endpackage

// File: rtl/rpc_ptr_unit.sv
module rpc_ptr_unit #(
  parameter int PTR_W    = 8,
  parameter int SIZE_W   = 9,
  parameter int DEF_SIZE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              size_we,
  input  logic [SIZE_W-1:0] size_wdata,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  wr_enq,
  input  logic [PTR_W-1:0]  wr_sw_deq,
  input  logic [PTR_W-1:0]  wr_ibi_deq,
  input  logic              done_i,
  output logic [SIZE_W-1:0] ring_size,
  output logic [PTR_W-1:0]  enq,
  output logic [PTR_W-1:0]  sw_deq,
  output logic [PTR_W-1:0]  ibi_deq,
  output logic [PTR_W-1:0]  hw_deq,
  output logic              empty_o,
  output logic              full_o,
  output logic              done_take_o
);
  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p,
                                            input logic [SIZE_W-1:0] sz);
    logic [SIZE_W-1:0] n;
    n = SIZE_W'(p) + SIZE_W'(1);
    if (n >= sz) step = '0;
    else         step = n[PTR_W-1:0];
  endfunction

  assign empty_o     = (enq == hw_deq);
  assign full_o      = (step(enq, ring_size) == hw_deq);
  assign done_take_o = done_i & ~empty_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_size <= SIZE_W'(DEF_SIZE);
      enq       <= '0;
      sw_deq    <= '0;
      ibi_deq   <= '0;
      hw_deq    <= '0;
    end else begin
      if (size_we) ring_size <= size_wdata;
      if (ptr_we) begin
        enq     <= wr_enq;
        sw_deq  <= wr_sw_deq;
        ibi_deq <= wr_ibi_deq;
      end
      if (done_take_o) hw_deq <= step(hw_deq, ring_size);
    end
  end
endmodule

// File: rtl/rpc_ring_ctl.sv
module rpc_ring_ctl
  import ring_ptr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ctrl_we,
  input  logic wr_enable,
  input  logic wr_halt,
  input  logic wr_abort,
  input  logic eng_busy_i,
  output logic enable_o,
  output logic halt_o,
  output logic locked_o,
  output logic aborted_o,
  output logic running_o,
  output logic ring_op_evt_o
);
  ring_state_e state_q;

  assign locked_o      = (state_q == RS_LOCKED);
  assign aborted_o     = (state_q == RS_ABORTED);
  assign running_o     = enable_o & ~halt_o & (state_q == RS_NORMAL);
  assign ring_op_evt_o = locked_o & ~eng_busy_i & ~ctrl_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= RS_NORMAL;
      enable_o <= 1'b0;
      halt_o   <= 1'b0;
    end else if (ctrl_we) begin
      enable_o <= wr_enable;
      halt_o   <= wr_halt;
      state_q  <= wr_abort ? RS_LOCKED : RS_NORMAL;
    end else if (ring_op_evt_o) begin
      state_q  <= RS_ABORTED;
    end
  end
endmodule

// File: rtl/rpc_irq_bank.sv
module rpc_irq_bank #(
  parameter int           W    = 13,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ack_we,
  input  logic         force_we,
  input  logic         sen_we,
  input  logic         sig_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] status_o,
  output logic [W-1:0] sen_o,
  output logic [W-1:0] sig_o,
  output logic         irq_o
);
  logic [W-1:0] sen_n, sig_n, set_v, clr_v, stat_n;

  always_comb begin
    sen_n  = sen_we ? (wdata & IMPL) : sen_o;
    sig_n  = sig_we ? (wdata & IMPL) : sig_o;
    set_v  = (evt | (force_we ? wdata : '0)) & sen_o & IMPL;
    clr_v  = ack_we ? wdata : '0;
    stat_n = (status_o & ~clr_v) | set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      sen_o    <= '0;
      sig_o    <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= stat_n;
      sen_o    <= sen_n;
      sig_o    <= sig_n;
      irq_o    <= |(stat_n & sig_n);
    end
  end
endmodule

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
  import ring_ptr_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int PTR_W       = 8,
  parameter int DEF_SIZE    = 16,
  parameter int XFER_STRUCT = 12,
  parameter int RESP_STRUCT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              eng_req_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic              eng_busy_i,
  input  logic [PTR_W-1:0]  ibi_hw_enq_i,
  input  logic              evt_ibi_ready_i,
  input  logic              evt_ins_stop_i,
  input  logic              evt_ibi_full_i,
  input  logic              evt_xfer_abort_i,
  output logic              ring_empty_o,
  output logic              ring_full_o,
  output logic              irq_o
);
  localparam int SIZE_W = PTR_W + 1;
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic ctrl_we, setup_we, ptr_we, ack_we, force_we, sen_we, sig_we;

  logic [SIZE_W-1:0] ring_size;
  logic [PTR_W-1:0]  enq, sw_deq, ibi_deq, hw_deq;
  logic              done_take;

  logic enable, halt, locked, aborted, running, ring_op_evt;

  logic [IRQ_W-1:0] irq_evt, irq_stat, irq_sen, irq_sig;
  logic [31:0]      rd_mux;
  logic             unused_bits;

  assign widx        = reg_addr[ADDR_W-1:2];
  assign unused_bits = ^{reg_addr[1:0], reg_wdata[31:24]};

  assign setup_we = reg_wr && (widx == WIDX_W'(REG_SETUP));
  assign ctrl_we  = reg_wr && (widx == WIDX_W'(REG_CTRL));
  assign ptr_we   = reg_wr && (widx == WIDX_W'(REG_PTRA));
  assign ack_we   = reg_wr && (widx == WIDX_W'(REG_ISTAT));
  assign sen_we   = reg_wr && (widx == WIDX_W'(REG_IEN));
  assign sig_we   = reg_wr && (widx == WIDX_W'(REG_ISIG));
  assign force_we = reg_wr && (widx == WIDX_W'(REG_IFORCE));

  rpc_ptr_unit #(
    .PTR_W   (PTR_W),
    .SIZE_W  (SIZE_W),
    .DEF_SIZE(DEF_SIZE)
  ) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .size_we    (setup_we),
    .size_wdata (reg_wdata[SIZE_W-1:0]),
    .ptr_we     (ptr_we),
    .wr_enq     (reg_wdata[0 +: PTR_W]),
    .wr_sw_deq  (reg_wdata[8 +: PTR_W]),
    .wr_ibi_deq (reg_wdata[16 +: PTR_W]),
    .done_i     (eng_done_i),
    .ring_size  (ring_size),
    .enq        (enq),
    .sw_deq     (sw_deq),
    .ibi_deq    (ibi_deq),
    .hw_deq     (hw_deq),
    .empty_o    (ring_empty_o),
    .full_o     (ring_full_o),
    .done_take_o(done_take)
  );

  rpc_ring_ctl u_ctl (
    .clk          (clk),
    .rst          (rst),
    .ctrl_we      (ctrl_we),
    .wr_enable    (reg_wdata[0]),
    .wr_halt      (reg_wdata[1]),
    .wr_abort     (reg_wdata[2]),
    .eng_busy_i   (eng_busy_i),
    .enable_o     (enable),
    .halt_o       (halt),
    .locked_o     (locked),
    .aborted_o    (aborted),
    .running_o    (running),
    .ring_op_evt_o(ring_op_evt)
  );

  assign eng_req_o = running & ~ring_empty_o;

  always_comb begin
    irq_evt                = '0;
    irq_evt[IRQ_IBI_RDY]   = evt_ibi_ready_i;
    irq_evt[IRQ_XFER_DONE] = done_take & ~eng_err_i;
    irq_evt[IRQ_RING_OP]   = ring_op_evt;
    irq_evt[IRQ_XFER_ERR]  = done_take & eng_err_i;
    irq_evt[IRQ_INS_STOP]  = evt_ins_stop_i;
    irq_evt[IRQ_IBI_FULL]  = evt_ibi_full_i;
    irq_evt[IRQ_XFER_ABT]  = evt_xfer_abort_i;
  end

  rpc_irq_bank #(
    .W   (IRQ_W),
    .IMPL(IRQ_IMPL)
  ) u_irq (
    .clk     (clk),
    .rst     (rst),
    .ack_we  (ack_we),
    .force_we(force_we),
    .sen_we  (sen_we),
    .sig_we  (sig_we),
    .wdata   (reg_wdata[IRQ_W-1:0]),
    .evt     (irq_evt),
    .status_o(irq_stat),
    .sen_o   (irq_sen),
    .sig_o   (irq_sig),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_mux = '0;
    case (widx)
      WIDX_W'(REG_SETUP): begin
        rd_mux[31:24]        = 8'(XFER_STRUCT);
        rd_mux[23:16]        = 8'(RESP_STRUCT);
        rd_mux[SIZE_W-1:0]   = ring_size;
      end
      WIDX_W'(REG_CTRL):  rd_mux[2:0] = {locked, halt, enable};
      WIDX_W'(REG_STATE): rd_mux[3:0] = {locked, aborted, running, enable};
      WIDX_W'(REG_PTRA): begin
        rd_mux[16 +: PTR_W] = ibi_deq;
        rd_mux[8 +: PTR_W]  = sw_deq;
        rd_mux[0 +: PTR_W]  = enq;
      end
      WIDX_W'(REG_PTRB): begin
        rd_mux[16 +: PTR_W] = ibi_hw_enq_i;
        rd_mux[0 +: PTR_W]  = hw_deq;
      end
      WIDX_W'(REG_ISTAT): rd_mux[IRQ_W-1:0] = irq_stat;
      WIDX_W'(REG_IEN):   rd_mux[IRQ_W-1:0] = irq_sen;
      WIDX_W'(REG_ISIG):  rd_mux[IRQ_W-1:0] = irq_sig;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/ring_ptr_ctrl_chk.sv
module ring_ptr_ctrl_chk
  import ring_ptr_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             eng_req_o,
  input logic             eng_done_i,
  input logic             eng_busy_i,
  input logic             ring_empty_o,
  input logic             irq_o,
  input logic             ctrl_we,
  input logic             running,
  input logic             locked,
  input logic [PTR_W-1:0] hw_deq,
  input logic [IRQ_W-1:0] irq_stat,
  input logic [IRQ_W-1:0] irq_sig
);
  // R4
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    eng_req_o |-> (running && !ring_empty_o));

  // R5
  hw_ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_done_i |=> $stable(hw_deq));

  // R5
  empty_done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_done_i && ring_empty_o) |=> $stable(hw_deq));

  // R12
  abort_finish_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !eng_busy_i && !ctrl_we) |=> !locked);

  // R10
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (|(irq_stat & irq_sig)));

  // R10
  irq_reach_chk: assert property (@(posedge clk) disable iff (rst)
    (|(irq_stat & irq_sig)) |-> irq_o);
endmodule

bind ring_ptr_ctrl ring_ptr_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .eng_req_o   (eng_req_o),
  .eng_done_i  (eng_done_i),
  .eng_busy_i  (eng_busy_i),
  .ring_empty_o(ring_empty_o),
  .irq_o       (irq_o),
  .ctrl_we     (ctrl_we),
  .running     (running),
  .locked      (locked),
  .hw_deq      (hw_deq),
  .irq_stat    (irq_stat),
  .irq_sig     (irq_sig)
);

// File: tb/ring_ptr_ctrl_test.sv
module ring_ptr_ctrl_test;
  localparam int A_SETUP  = 6'h00;
  localparam int A_CTRL   = 6'h04;
  localparam int A_STATE  = 6'h08;
  localparam int A_PTRA   = 6'h0C;
  localparam int A_PTRB   = 6'h10;
  localparam int A_ISTAT  = 6'h14;
  localparam int A_IEN    = 6'h18;
  localparam int A_ISIG   = 6'h1C;
  localparam int A_IFORCE = 6'h20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_req_o, ring_empty_o, ring_full_o, irq_o;
  logic        eng_done_i = 1'b0, eng_err_i = 1'b0, eng_busy_i = 1'b0;
  logic [7:0]  ibi_hw_enq_i = '0;
  logic        evt_ibi_ready_i = 1'b0, evt_ins_stop_i = 1'b0;
  logic        evt_ibi_full_i = 1'b0, evt_xfer_abort_i = 1'b0;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  ring_ptr_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_req_o(eng_req_o), .eng_done_i(eng_done_i), .eng_err_i(eng_err_i),
    .eng_busy_i(eng_busy_i), .ibi_hw_enq_i(ibi_hw_enq_i),
    .evt_ibi_ready_i(evt_ibi_ready_i), .evt_ins_stop_i(evt_ins_stop_i),
    .evt_ibi_full_i(evt_ibi_full_i), .evt_xfer_abort_i(evt_xfer_abort_i),
    .ring_empty_o(ring_empty_o), .ring_full_o(ring_full_o), .irq_o(irq_o)
  );

  always @(posedge clk) rd_seen <= reg_rd;

  // monitor: compares registered read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (reg_rdata !== e) begin
        bad++;
        $display("FAIL %s: got %08h expected %08h", t, reg_rdata, e);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 6'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = 6'(a);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic done_pulse(input logic err);
    eng_done_i = 1'b1; eng_err_i = err;
    @(negedge clk);
    eng_done_i = 1'b0; eng_err_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(eng_req_o, 1'b0, "R1 req");
    chk(irq_o, 1'b0, "R1 irq");
    chk(ring_empty_o, 1'b1, "R1 empty");
    chk(ring_full_o, 1'b0, "R1 full");
    rd(A_SETUP, 32'h0C04_0010, "R1 setup");
    rd(A_CTRL, 32'h0, "R1 ctrl");
    rd(A_STATE, 32'h0, "R1 state");
    rd(A_PTRA, 32'h0, "R1 ptrA");
    rd(A_ISTAT, 32'h0, "R1 istat");

    // R2 packed software pointers
    wr(A_PTRA, 32'hAB05_0307);
    rd(A_PTRA, 32'h0005_0307, "R2 ptrA fields");

    // R3 read-only hardware word
    ibi_hw_enq_i = 8'h2A;
    wr(A_PTRB, 32'hFFFF_FFFF);
    rd(A_PTRB, 32'h002A_0000, "R3 ptrB ignore write");

    // R4 request gating
    chk(eng_req_o, 1'b0, "R4 disabled");
    wr(A_CTRL, 32'h1);
    chk(eng_req_o, 1'b1, "R4 running");
    rd(A_STATE, 32'h3, "R4 state running");
    wr(A_CTRL, 32'h3);
    chk(eng_req_o, 1'b0, "R4 halted");
    rd(A_STATE, 32'h1, "R4 state halted");
    wr(A_CTRL, 32'h1);

    // R8 status not recorded while disabled
    done_pulse(1'b0);
    rd(A_ISTAT, 32'h0, "R8 not enabled");
    rd(A_PTRB, 32'h002A_0001, "R5 advance");
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, 32'h0000_1EE0, "R8 implemented mask");

    // R7 complete vs error
    done_pulse(1'b0);
    rd(A_ISTAT, 32'h800, "R7 complete");
    done_pulse(1'b1);
    rd(A_ISTAT, 32'hA00, "R7 error");
    rd(A_PTRB, 32'h002A_0003, "R5 advance x3");
    chk(irq_o, 1'b0, "R10 unsignalled");

    // R10 / R9
    wr(A_ISIG, 32'h200);
    chk(irq_o, 1'b1, "R10 signalled");
    wr(A_ISTAT, 32'h200);
    chk(irq_o, 1'b0, "R10 after clear");
    rd(A_ISTAT, 32'h800, "R9 w1c");

    // R11 force and event-vs-clear
    wr(A_IFORCE, 32'h1000);
    rd(A_ISTAT, 32'h1800, "R11 force");
    evt_ins_stop_i = 1'b1;
    wr(A_ISTAT, 32'h80);
    evt_ins_stop_i = 1'b0;
    rd(A_ISTAT, 32'h1880, "R11 event beats clear");

    // R13 event mapping
    wr(A_ISTAT, 32'h1000);
    evt_ibi_ready_i = 1'b1; evt_ibi_full_i = 1'b1; evt_xfer_abort_i = 1'b1;
    @(negedge clk);
    evt_ibi_ready_i = 1'b0; evt_ibi_full_i = 1'b0; evt_xfer_abort_i = 1'b0;
    rd(A_ISTAT, 32'h18E0, "R13 event bits");
    wr(A_ISTAT, 32'hFFFF_FFFF);
    rd(A_ISTAT, 32'h0, "R9 clear all");
    wr(A_IEN, 32'h0);
    wr(A_IFORCE, 32'h1EE0);
    rd(A_ISTAT, 32'h0, "R11 force gated");
    wr(A_IEN, 32'hFFFF_FFFF);

    // R6 full / empty, R5 ignore on empty
    wr(A_PTRA, 32'h2);
    chk(ring_full_o, 1'b1, "R6 full");
    chk(ring_empty_o, 1'b0, "R6 not empty");
    wr(A_PTRA, 32'h3);
    chk(ring_empty_o, 1'b1, "R6 empty");
    chk(ring_full_o, 1'b0, "R6 not full");
    chk(eng_req_o, 1'b0, "R4 empty no req");
    done_pulse(1'b0);
    rd(A_PTRB, 32'h002A_0003, "R5 empty done ignored");
    rd(A_ISTAT, 32'h0, "R5 empty done no irq");

    // R5 wrap at programmed size
    wr(A_SETUP, 32'h4);
    rd(A_SETUP, 32'h0C04_0004, "R5 size");
    wr(A_PTRA, 32'h1);
    done_pulse(1'b0);
    rd(A_PTRB, 32'h002A_0000, "R5 wrap");
    chk(ring_empty_o, 1'b0, "R6 after wrap");
    done_pulse(1'b0);
    chk(ring_empty_o, 1'b1, "R6 drained");
    wr(A_PTRA, 32'h0);
    chk(ring_full_o, 1'b1, "R6 full across wrap");
    wr(A_PTRA, 32'h3);
    wr(A_ISTAT, 32'hFFFF_FFFF);

    // R12 abort and restart
    eng_busy_i = 1'b1;
    wr(A_CTRL, 32'h5);
    chk(eng_req_o, 1'b0, "R12 locked no req");
    rd(A_STATE, 32'h9, "R12 locked");
    rd(A_ISTAT, 32'h0, "R12 busy no ring-op");
    eng_busy_i = 1'b0;
    @(negedge clk);
    rd(A_STATE, 32'h5, "R12 aborted");
    rd(A_ISTAT, 32'h400, "R12 ring-op");
    chk(irq_o, 1'b0, "R12 ring-op unsignalled");
    wr(A_CTRL, 32'h1);
    rd(A_STATE, 32'h3, "R12 restart");
    chk(eng_req_o, 1'b1, "R12 restart req");

    @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule